// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog timer on a small 32-bit register bus. It has a 64-bit up-counter and a 64-bit period, each visible as a low and a high 32-bit word. There is a run-control register, a timer-setup register and a watchdog command register. Software configures the counter, arms the watchdog by writing two fixed 16-bit keys in order, and services it later by writing the same two keys again. Once arming begins, the block locks its own configuration. After that, only the key field of the command register still has any effect.

A fault raises a one-cycle reset request and sets a sticky timeout flag. The block treats two events as faults: the counter reaching the period while the watchdog is active, and a key write that breaks the expected sequence. The flag stays set until the next system reset, so software can check it after a restart. Bus reads are registered and return data one clock after the read strobe.

Word addresses: 0 counter low, 1 counter high, 2 period low, 3 period high, 4 run control, 5 timer setup, 6 watchdog command. Other addresses read as zero.

Top module: `kwdt_top`

## Requirements
- R1: After reset, all seven registers read 0 and `reset_req` is low. A read returns the data one clock after the cycle in which `rd_en` is high.
- R2: The counter advances by one per clock only when all of the following hold: run-control bits 7:6 are nonzero, timer-setup bits 0 and 1 are both 1, and timer-setup bits 3:2 equal 2. Otherwise it holds its value.
- R3: When the running counter equals the period, the next value depends on the run-control mode. With mode 2 (continuous) it becomes 0. With mode 1 (one-shot) it stays at the period.
- R4: The watchdog command word carries the key in bits 31:16 and the enable bit in bit 14. In the disabled state, key 0xA5C6 with the enable bit set moves the watchdog to pre-active. Any other write in the disabled state has no effect, including 0xA5C6 without the enable bit. From pre-active, key 0xDA7E moves it to active.
- R5: In the pre-active, active and service states, writes to addresses 0 to 5 are ignored.
- R6: In the active state, key 0xA5C6 enters the service state. Key 0xDA7E then returns to active and clears the counter to 0. Neither write raises a reset request.
- R7: In the active or service state, a running counter that equals the period sets the timeout flag. `reset_req` is high in the following cycle.
- R8: A key write breaks the sequence if its key is not 0xDA7E in pre-active, not 0xA5C6 in active, or not 0xDA7E in service. Such a write raises `reset_req` in the next cycle and sets the timeout flag.
- R9: `reset_req` lasts one cycle and fires at most once until a system reset. The bus cannot clear the timeout flag.
- R10: A read of the watchdog command register returns 0 in bits 31:16, the timeout flag in bit 15, the enable bit in bit 14 and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| reset_req | output | 1 | One-cycle reset request |

## Verification
On every cycle, the assertions check the following properties:
- the counter holds when it is not allowed to run;
- at the period, the counter wraps in continuous mode and holds in one-shot mode;
- a service restart leaves the counter at zero;
- locked writes leave the configuration unchanged;
- a broken key sequence or a timeout leads to a request, and the request is a single cycle;
- the flag is sticky.

Other properties need the bench's scenarios:
- the exact clock on which a timeout request appears for each period value;
- the count values read back over time in both modes;
- each bad key rejected in each state;
- the layout of the command register as software sees it.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned HALF_W   = 32;
  localparam int unsigned CNT_W    = 2 * HALF_W;
  localparam int unsigned KEY_W    = 16;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned EN_BIT   = 14;
  localparam int unsigned FLAG_BIT = 15;

  typedef enum logic [1:0] {
    WD_OFF = 2'd0,
    WD_PRE = 2'd1,
    WD_ACT = 2'd2,
    WD_SVC = 2'd3
  } wd_state_e;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_PRD_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRD_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_RUNCTL = 3'd4;
  localparam logic [ADDR_W-1:0] A_SETUP  = 3'd5;
  localparam logic [ADDR_W-1:0] A_WDCMD  = 3'd6;

  localparam logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E;

  localparam logic [1:0] EMODE_OFF  = 2'd0;
  localparam logic [1:0] EMODE_ONCE = 2'd1;
  localparam logic [1:0] SMODE_WDOG = 2'd2;

  // counter may advance: mode nonzero, both halves released, watchdog mode
  function automatic logic f_run(input logic [1:0] emode, input logic [3:0] setup);
    return (emode != EMODE_OFF) && setup[0] && setup[1] && (setup[3:2] == SMODE_WDOG);
  endfunction

  // next counter value for a free step
  function automatic logic [CNT_W-1:0] f_next(input logic [CNT_W-1:0] cnt,
                                               input logic [CNT_W-1:0] prd,
                                               input logic run, input logic once);
    if (!run)            return cnt;
    else if (cnt == prd) return once ? cnt : '0;
    else                 return cnt + 1'b1;
  endfunction

  // software view of the watchdog command register
  function automatic logic [HALF_W-1:0] f_cmd_view(input logic flag, input logic en);
    logic [HALF_W-1:0] v;
    v = '0;
    v[FLAG_BIT] = flag;
    v[EN_BIT]   = en;
    return v;
  endfunction
endpackage

// File: rtl/kwdt_cfg.sv
module kwdt_cfg
  import kwdt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                locked,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [HALF_W-1:0]   wdata,
  output logic [CNT_W-1:0]    prd_q,
  output logic [1:0]          emode_q,
  output logic [3:0]          setup_q,
  output logic                cnt_wr_lo,
  output logic                cnt_wr_hi
);
  logic cfg_wr;
  logic [HALF_W-1:0] prd_h [2];

  assign cfg_wr    = wr_en & ~locked;
  assign cnt_wr_lo = cfg_wr && (addr == A_CNT_LO);
  assign cnt_wr_hi = cfg_wr && (addr == A_CNT_HI);

  for (genvar h = 0; h < 2; h++) begin : g_prd
    localparam logic [ADDR_W-1:0] MY_ADDR = (h == 0) ? A_PRD_LO : A_PRD_HI;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        prd_h[h] <= '0;
      else if (cfg_wr && addr == MY_ADDR) prd_h[h] <= wdata;
    end
  end
  assign prd_q = {prd_h[1], prd_h[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emode_q <= EMODE_OFF;
      setup_q <= '0;
    end else if (cfg_wr) begin
      if (addr == A_RUNCTL) emode_q <= wdata[7:6];
      if (addr == A_SETUP)  setup_q <= wdata[3:0];
    end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en) |=> ($stable(prd_q) && $stable(emode_q) && $stable(setup_q)))
    else $error("locked configuration changed"); // R5
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               once,
  input  logic               restart,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [HALF_W-1:0]  wdata,
  input  logic [CNT_W-1:0]   prd,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               at_period
);
  logic any_wr;
  assign any_wr    = wr_lo | wr_hi;
  assign at_period = (cnt_q == prd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (any_wr) begin
      if (wr_lo) cnt_q[HALF_W-1:0]     <= wdata;
      if (wr_hi) cnt_q[CNT_W-1:HALF_W] <= wdata;
    end else           cnt_q <= f_next(cnt_q, prd, run, once);
  end

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart && !any_wr) |=> $stable(cnt_q))
    else $error("counter moved while stopped"); // R2
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !once && at_period && !restart && !any_wr) |=> (cnt_q == '0))
    else $error("continuous counter did not wrap"); // R3
  AST_CNT_HOLD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && once && at_period && !restart && !any_wr) |=> $stable(cnt_q))
    else $error("one-shot counter left the period"); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0))
    else $error("service did not clear counter"); // R6
endmodule

// File: rtl/kwdt_keyfsm.sv
module kwdt_keyfsm
  import kwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [KEY_W-1:0]  key,
  input  logic              en_bit,
  input  logic              expire,
  output logic              locked,
  output logic              restart,
  output logic              en_q,
  output logic              flag_q,
  output logic              reset_req
);
  wd_state_e state_q, state_d;
  logic arm_evt, bad_evt, tmo_evt, fire;

  always_comb begin
    state_d = state_q;
    arm_evt = 1'b0;
    bad_evt = 1'b0;
    restart = 1'b0;
    if (cmd_wr) begin
      case (state_q)
        WD_OFF: if (key == KEY_FIRST && en_bit) begin
                  state_d = WD_PRE;
                  arm_evt = 1'b1;
                end
        WD_PRE: if (key == KEY_SECOND) state_d = WD_ACT;
                else                   bad_evt = 1'b1;
        WD_ACT: if (key == KEY_FIRST)  state_d = WD_SVC;
                else                   bad_evt = 1'b1;
        WD_SVC: if (key == KEY_SECOND) begin
                  state_d = WD_ACT;
                  restart = 1'b1;
                end else               bad_evt = 1'b1;
        default: state_d = WD_OFF;
      endcase
    end
  end

  assign locked  = (state_q != WD_OFF);
  assign tmo_evt = ((state_q == WD_ACT) || (state_q == WD_SVC)) && expire;
  assign fire    = tmo_evt | bad_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= WD_OFF;
      en_q      <= 1'b0;
      flag_q    <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      state_q   <= state_d;
      en_q      <= en_q | arm_evt;
      flag_q    <= flag_q | fire;
      reset_req <= fire & ~flag_q;
    end
  end

  AST_OFF_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_OFF && cmd_wr && !(key == KEY_FIRST && en_bit)) |=> (state_q == WD_OFF && !reset_req))
    else $error("disabled state reacted to a non-arming write"); // R4
  AST_BAD_KEY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_evt && !flag_q) |=> (reset_req && flag_q))
    else $error("bad key did not request reset"); // R8
  AST_TMO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt && !flag_q) |=> (reset_req && flag_q))
    else $error("timeout did not request reset"); // R7
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req)
    else $error("reset request longer than a cycle"); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q)
    else $error("timeout flag cleared"); // R9
  AST_REQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> flag_q)
    else $error("request without flag"); // R7
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [HALF_W-1:0]  wdata,
  output logic [HALF_W-1:0]  rdata,
  output logic               reset_req
);
  logic [CNT_W-1:0] prd_q, cnt_q;
  logic [1:0]       emode_q;
  logic [3:0]       setup_q;
  logic cnt_wr_lo, cnt_wr_hi, locked, restart, en_q, flag_q, at_period, run, cmd_wr;
  logic [HALF_W-1:0] rd_mux;

  assign run    = f_run(emode_q, setup_q);
  assign cmd_wr = wr_en && (addr == A_WDCMD);

  kwdt_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .locked(locked), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .prd_q(prd_q), .emode_q(emode_q), .setup_q(setup_q),
    .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi)
  );

  kwdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .once(emode_q == EMODE_ONCE),
    .restart(restart), .wr_lo(cnt_wr_lo), .wr_hi(cnt_wr_hi), .wdata(wdata),
    .prd(prd_q), .cnt_q(cnt_q), .at_period(at_period)
  );

  kwdt_keyfsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .key(wdata[HALF_W-1 -: KEY_W]),
    .en_bit(wdata[EN_BIT]), .expire(run && at_period), .locked(locked),
    .restart(restart), .en_q(en_q), .flag_q(flag_q), .reset_req(reset_req)
  );

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CNT_LO: rd_mux = cnt_q[HALF_W-1:0];
      A_CNT_HI: rd_mux = cnt_q[CNT_W-1:HALF_W];
      A_PRD_LO: rd_mux = prd_q[HALF_W-1:0];
      A_PRD_HI: rd_mux = prd_q[CNT_W-1:HALF_W];
      A_RUNCTL: rd_mux[7:6] = emode_q;
      A_SETUP:  rd_mux[3:0] = setup_q;
      A_WDCMD:  rd_mux = f_cmd_view(flag_q, en_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] K1 = 16'hA5C6;
  localparam logic [15:0] K2 = 16'hDA7E;
  localparam logic [15:0] ENB = 16'h4000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic reset_req;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kwdt_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .reset_req(reset_req)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  // stage: 1 pre-active, 2 active, 3 service
  task automatic arm_to(input int stage);
    bus_wr(3'd6, {K1, ENB});
    if (stage >= 2) bus_wr(3'd6, {K2, ENB});
    if (stage >= 3) bus_wr(3'd6, {K1, ENB});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    logic [15:0] bad_pre [4] = '{16'h0000, K1, 16'hFFFF, 16'hDA7F};
    logic [15:0] bad_act [4] = '{16'h0000, K2, 16'hA5C7, 16'h5A39};
    logic [15:0] bad_svc [3] = '{K1, 16'h0000, 16'hFFFF};
    logic [31:0] lock_val [6] = '{32'h11, 32'h22, 32'h33, 32'h44, 32'h40, 32'h3};

    // R1 reset state
    sys_reset();
    chk("R1 reset_req", {31'd0, reset_req}, 32'd0);
    for (int a = 0; a < 7; a++) begin
      bus_rd(a[2:0], v);
      chk($sformatf("R1 reg %0d", a), v, 32'd0);
    end

    // R2 run-condition sweep over all setup and mode values
    bus_wr(3'd3, 32'hFFFF_FFFF);
    for (int g = 0; g < 16; g++) begin
      for (int m = 0; m < 4; m++) begin
        bus_wr(3'd5, g);
        bus_wr(3'd4, m << 6);
        bus_rd(3'd0, v);
        bus_rd(3'd0, v2);
        chk($sformatf("R2 g=%0d m=%0d step", g, m), v2 - v,
            ((m != 0) && (g[1:0] == 2'b11) && (g[3:2] == 2'b10)) ? 32'd2 : 32'd0);
      end
    end
    bus_rd(3'd4, v); chk("R2 runctl readback", v, 32'hC0);
    bus_rd(3'd5, v); chk("R2 setup readback", v, 32'hF);

    // R3 count sequence at the period, both modes
    for (int once = 0; once < 2; once++) begin
      for (int p = 1; p <= 6; p++) begin
        sys_reset();
        bus_wr(3'd2, p);
        bus_wr(3'd4, once ? 32'h40 : 32'h80);
        bus_wr(3'd5, 32'hB);
        for (int k = 0; k < 8; k++) begin
          int s;
          s = 1 + 2 * k;
          bus_rd(3'd0, v);
          chk($sformatf("R3 once=%0d p=%0d k=%0d", once, p, k), v,
              once ? ((s < p) ? s : p) : (s % (p + 1)));
        end
      end
    end

    // R4 arming order; R10 command view; R5 lock on arming; R6 no request on service
    sys_reset();
    bus_wr(3'd6, {K1, 16'h0000});
    chk("R4 key without enable no request", {31'd0, reset_req}, 32'd0);
    bus_wr(3'd0, 32'd5); bus_rd(3'd0, v);
    chk("R4 still unlocked after key without enable", v, 32'd5);
    bus_wr(3'd6, {K2, ENB});
    chk("R4 second key while disabled no request", {31'd0, reset_req}, 32'd0);
    bus_wr(3'd0, 32'd7); bus_rd(3'd0, v);
    chk("R4 still unlocked after second key", v, 32'd7);
    bus_rd(3'd6, v); chk("R10 view disabled", v, 32'd0);
    bus_wr(3'd6, {K1, ENB});
    bus_rd(3'd6, v); chk("R10 view armed", v, 32'h0000_4000);
    bus_wr(3'd0, 32'd9); bus_rd(3'd0, v);
    chk("R5 locked after arming", v, 32'd7);
    bus_wr(3'd6, {K2, ENB});
    chk("R4 to active no request", {31'd0, reset_req}, 32'd0);
    bus_wr(3'd6, {K1, 16'h0});
    chk("R6 enter service no request", {31'd0, reset_req}, 32'd0);
    bus_wr(3'd6, {K2, 16'h0});
    chk("R6 leave service no request", {31'd0, reset_req}, 32'd0);

    // R5 lock sweep in pre-active and active
    for (int st = 1; st <= 2; st++) begin
      sys_reset();
      for (int a = 0; a < 6; a++) bus_wr(a[2:0], lock_val[a]);
      arm_to(st);
      for (int a = 0; a < 6; a++) bus_wr(a[2:0], 32'hFFFF_FFFF);
      for (int a = 0; a < 6; a++) begin
        bus_rd(a[2:0], v);
        chk($sformatf("R5 stage=%0d reg %0d", st, a), v, lock_val[a]);
      end
    end

    // R8 wrong keys in each armed state; R9 pulse width; R10 flag bit
    for (int st = 1; st <= 3; st++) begin
      for (int i = 0; i < ((st == 3) ? 3 : 4); i++) begin
        logic [15:0] kb;
        kb = (st == 1) ? bad_pre[i] : (st == 2) ? bad_act[i] : bad_svc[i];
        sys_reset();
        arm_to(st);
        bus_wr(3'd6, {kb, ENB});
        chk($sformatf("R8 stage=%0d key=%h request", st, kb), {31'd0, reset_req}, 32'd1);
        @(negedge clk);
        chk($sformatf("R9 stage=%0d key=%h one cycle", st, kb), {31'd0, reset_req}, 32'd0);
        bus_rd(3'd6, v);
        chk($sformatf("R10 stage=%0d key=%h flag view", st, kb), v, 32'h0000_C000);
      end
    end

    // R7 timeout timing sweep; R9 single request and sticky flag
    for (int p = 1; p <= 10; p++) begin
      sys_reset();
      bus_wr(3'd1, 32'd1);
      bus_wr(3'd2, p);
      bus_wr(3'd5, 32'hB);
      bus_wr(3'd4, 32'h80);
      arm_to(3);
      bus_wr(3'd6, {K2, ENB});
      for (int n = 1; n <= p + 4; n++) begin
        @(negedge clk);
        chk($sformatf("R7 p=%0d cycle %0d", p, n), {31'd0, reset_req}, (n == p + 1) ? 32'd1 : 32'd0);
      end
      bus_rd(3'd6, v); chk($sformatf("R7 p=%0d flag", p), v, 32'h0000_C000);
      bus_wr(3'd6, 32'h0000_0000);
      chk($sformatf("R9 p=%0d no second request", p), {31'd0, reset_req}, 32'd0);
      bus_rd(3'd6, v); chk($sformatf("R9 p=%0d flag kept", p), v, 32'h0000_C000);
    end

    // R6 repeated service keeps the watchdog alive and zeroes the count
    sys_reset();
    bus_wr(3'd1, 32'd1);
    bus_wr(3'd2, 32'd12);
    bus_wr(3'd5, 32'hB);
    bus_wr(3'd4, 32'h80);
    arm_to(2);
    for (int r = 0; r < 5; r++) begin
      bus_wr(3'd6, {K1, ENB});
      bus_wr(3'd6, {K2, ENB});
      bus_rd(3'd0, v);
      chk($sformatf("R6 service %0d count", r), v, 32'd1);
      for (int w = 0; w < 4; w++) begin
        @(negedge clk);
        chk($sformatf("R6 service %0d quiet", r), {31'd0, reset_req}, 32'd0);
      end
    end
    bus_rd(3'd6, v); chk("R6 no flag after services", v, 32'h0000_4000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule